// File: doc/BRIEF.md
# Split Nibble Register File

This block holds eight 4-bit registers that can be reached through two views of the same storage. In the narrow view, every register has its own read port and its own write port. Each port is selected by one enable bit per register, so all eight registers can be read and written in the same cycle. In the wide view, one extra read port and one extra write port move all eight registers at once as a single packed 32-bit word. In that word, register k sits in bits [4k+3:4k], and register 0 holds the least significant bits.

Writes are sampled on a clock edge and become visible in storage after that edge. Reads are combinational. A read in the same cycle as a write to the same register returns the incoming data (write-through). This also holds on the wide read, one nibble at a time.

When the wide write and a narrow write hit the same register in one cycle, the narrow write wins for that register. The wide write still lands in every other register. A read port whose enable is low drives zero.

Top module: `nibrf_split`

## Requirements
- R1: While rst_ni is low, all eight registers are cleared to zero. After release, every enabled read returns 0 until a write occurs.
- R2: A narrow write with nwr_en_i[k] high stores nibble k of nwr_data_i on the rising edge. From the next cycle, an enabled read of register k returns that value until the register is written again.
- R3: When nrd_en_i[k] is low, bits [4k+3:4k] of nrd_data_o are zero.
- R4: When nrd_en_i[k] and nwr_en_i[k] are both high in the same cycle, nibble k of nrd_data_o equals nibble k of nwr_data_i in that cycle.
- R5: A wide write with wwr_en_i high stores bits [4k+3:4k] of wwr_data_i into register k, for all k, on one edge.
- R6: With wrd_en_i high, wrd_data_o bits [4k+3:4k] hold register k. With wrd_en_i low, wrd_data_o is zero.
- R7: When wwr_en_i and nwr_en_i[k] are high in the same cycle, register k takes the narrow data. Every register j whose narrow enable is low takes the wide data.
- R8: During a wide read, each nibble is bypassed on its own. It shows the narrow write data if that register is narrowly written, otherwise the wide write data if wwr_en_i is high, otherwise the stored value.
- R9: All eight narrow read and write ports act independently in one cycle, with any mix of enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nrd_en_i | input | 8 | Narrow read enables, one bit per register |
| nrd_data_o | output | 32 | Narrow read data, nibble k for port k |
| nwr_en_i | input | 8 | Narrow write enables, one bit per register |
| nwr_data_i | input | 32 | Narrow write data, nibble k for port k |
| wrd_en_i | input | 1 | Wide read enable |
| wrd_data_o | output | 32 | Wide read data, all registers packed |
| wwr_en_i | input | 1 | Wide write enable |
| wwr_data_i | input | 32 | Wide write data, all registers packed |

## Verification
The hardest situation to reach is a single cycle in which the wide write, several narrow writes and both read views all overlap. In that cycle, each nibble of the wide read has to resolve its own bypass source, and the narrow writes must override only some of the registers. Directed cycles set up partial enable masks such as alternating bits. They place a wide write over those masks while both read views are enabled. Long runs of random enable vectors then produce every mix of bypass source per nibble.

// File: rtl/nibrf_pkg.sv
package nibrf_pkg;
  parameter int unsigned NRF_ENTRIES = 8;
  parameter int unsigned NRF_NIB_W   = 4;
  parameter int unsigned NRF_WORD_W  = NRF_ENTRIES * NRF_NIB_W;

  // write source chosen for one register in a cycle
  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_WIDE   = 2'd1,
    SRC_NARROW = 2'd2
  } wr_src_e;
endpackage

// File: rtl/nibrf_cell.sv
module nibrf_cell #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nwr_en_i,
  input  logic [NIB_W-1:0] nwr_nib_i,
  input  logic             wwr_en_i,
  input  logic [NIB_W-1:0] wwr_nib_i,
  output logic [NIB_W-1:0] view_o
);
  import nibrf_pkg::*;

  wr_src_e          src;
  logic [NIB_W-1:0] q, d;

  // narrow port has priority over the wide port
  always_comb begin
    if (nwr_en_i)      src = SRC_NARROW;
    else if (wwr_en_i) src = SRC_WIDE;
    else               src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_NARROW: d = nwr_nib_i;
      SRC_WIDE:   d = wwr_nib_i;
      default:    d = q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  // write-through view: the value the register will hold after this edge
  assign view_o = d;
endmodule

// File: rtl/nibrf_rd_gate.sv
module nibrf_rd_gate #(
  parameter int unsigned W = 4
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  assign d_o = en_i ? d_i : '0;
endmodule

// File: rtl/nibrf_split.sv
module nibrf_split #(
  parameter int unsigned ENTRIES = nibrf_pkg::NRF_ENTRIES,
  parameter int unsigned NIB_W   = nibrf_pkg::NRF_NIB_W,
  localparam int unsigned WORD_W = ENTRIES * NIB_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] nrd_en_i,
  output logic [WORD_W-1:0]  nrd_data_o,
  input  logic [ENTRIES-1:0] nwr_en_i,
  input  logic [WORD_W-1:0]  nwr_data_i,
  input  logic               wrd_en_i,
  output logic [WORD_W-1:0]  wrd_data_o,
  input  logic               wwr_en_i,
  input  logic [WORD_W-1:0]  wwr_data_i
);
  logic [WORD_W-1:0] view_word;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    nibrf_cell #(.NIB_W(NIB_W)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .nwr_en_i  (nwr_en_i[g]),
      .nwr_nib_i (nwr_data_i[g*NIB_W +: NIB_W]),
      .wwr_en_i  (wwr_en_i),
      .wwr_nib_i (wwr_data_i[g*NIB_W +: NIB_W]),
      .view_o    (view_word[g*NIB_W +: NIB_W])
    );

    nibrf_rd_gate #(.W(NIB_W)) u_nrd (
      .en_i (nrd_en_i[g]),
      .d_i  (view_word[g*NIB_W +: NIB_W]),
      .d_o  (nrd_data_o[g*NIB_W +: NIB_W])
    );
  end

  nibrf_rd_gate #(.W(WORD_W)) u_wrd (
    .en_i (wrd_en_i),
    .d_i  (view_word),
    .d_o  (wrd_data_o)
  );
endmodule

// File: rtl/nibrf_split_chk.sv
module nibrf_split_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned NIB_W   = 4,
  localparam int unsigned WORD_W = ENTRIES * NIB_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ENTRIES-1:0] nrd_en_i,
  input logic [WORD_W-1:0]  nrd_data_o,
  input logic [ENTRIES-1:0] nwr_en_i,
  input logic [WORD_W-1:0]  nwr_data_i,
  input logic               wrd_en_i,
  input logic [WORD_W-1:0]  wrd_data_o,
  input logic               wwr_en_i,
  input logic [WORD_W-1:0]  wwr_data_i
);
  for (genvar k = 0; k < ENTRIES; k++) begin : g_k
    p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !nrd_en_i[k] |-> nrd_data_o[k*NIB_W +: NIB_W] == '0);

    p_bypass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nrd_en_i[k] && nwr_en_i[k]) |->
        nrd_data_o[k*NIB_W +: NIB_W] == nwr_data_i[k*NIB_W +: NIB_W]);

    p_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nwr_en_i[k] |=> ((nrd_en_i[k] && !nwr_en_i[k] && !wwr_en_i) ->
        nrd_data_o[k*NIB_W +: NIB_W] == $past(nwr_data_i[k*NIB_W +: NIB_W])));

    p_wide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrd_en_i && wwr_en_i && !nwr_en_i[k]) |->
        wrd_data_o[k*NIB_W +: NIB_W] == wwr_data_i[k*NIB_W +: NIB_W]);

    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nrd_en_i[k] && !nwr_en_i[k] && !wwr_en_i) |=>
        ((nrd_en_i[k] && !nwr_en_i[k] && !wwr_en_i) ->
          $stable(nrd_data_o[k*NIB_W +: NIB_W])));
  end

  p_conflict_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wwr_en_i && nwr_en_i[0]) |=> ((nrd_en_i[0] && !nwr_en_i[0] && !wwr_en_i) ->
      nrd_data_o[NIB_W-1:0] == $past(nwr_data_i[NIB_W-1:0])));

  p_wide_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrd_en_i |-> wrd_data_o == '0);
endmodule

bind nibrf_split nibrf_split_chk #(.ENTRIES(ENTRIES), .NIB_W(NIB_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nrd_en_i   (nrd_en_i),
  .nrd_data_o (nrd_data_o),
  .nwr_en_i   (nwr_en_i),
  .nwr_data_i (nwr_data_i),
  .wrd_en_i   (wrd_en_i),
  .wrd_data_o (wrd_data_o),
  .wwr_en_i   (wwr_en_i),
  .wwr_data_i (wwr_data_i)
);

// File: tb/nibrf_split_test.sv
`timescale 1ns/1ps
module nibrf_split_test;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  nrd_en_i = '0, nwr_en_i = '0;
  logic [31:0] nwr_data_i = '0, wwr_data_i = '0;
  logic        wrd_en_i = 1'b0, wwr_en_i = 1'b0;
  logic [31:0] nrd_data_o, wrd_data_o;

  int n_chk = 0, n_fail = 0;
  int mdl [N];
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  nibrf_split uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .nrd_en_i(nrd_en_i), .nrd_data_o(nrd_data_o),
    .nwr_en_i(nwr_en_i), .nwr_data_i(nwr_data_i),
    .wrd_en_i(wrd_en_i), .wrd_data_o(wrd_data_o),
    .wwr_en_i(wwr_en_i), .wwr_data_i(wwr_data_i)
  );

  function automatic int nib(logic [31:0] w, int k);
    return int'((w >> (4*k)) & 32'hF);
  endfunction

  // value a read of register k must show this cycle
  function automatic int seen(int k);
    if (nwr_en_i[k]) return nib(nwr_data_i, k);
    if (wwr_en_i)    return nib(wwr_data_i, k);
    return mdl[k];
  endfunction

  task automatic check(string req, int k, string view, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s nibble %0d: actual %0h expected %0h", req, view, k, act, exp);
    end
  endtask

  // compare both views against the model, then commit on the edge
  task automatic cycle(string base);
    #1;
    for (int k = 0; k < N; k++) begin
      string rq, wq;
      if (!nrd_en_i[k])     rq = "R3";
      else if (nwr_en_i[k]) rq = "R4";
      else                  rq = base;
      check(rq, k, "narrow", nib(nrd_data_o, k), nrd_en_i[k] ? seen(k) : 0);
      if (!wrd_en_i)                    wq = "R6";
      else if (nwr_en_i[k] || wwr_en_i) wq = (nwr_en_i[k] && wwr_en_i) ? "R7" : "R8";
      else                              wq = base;
      check(wq, k, "wide", nib(wrd_data_o, k), wrd_en_i ? seen(k) : 0);
    end
    @(posedge clk_i);
    if (rst_ni) for (int k = 0; k < N; k++) mdl[k] = seen(k);
    @(negedge clk_i);
  endtask

  task automatic drive(logic [7:0] nre, logic [7:0] nwe, logic [31:0] nwd,
                       logic wre, logic wwe, logic [31:0] wwd);
    nrd_en_i = nre; nwr_en_i = nwe; nwr_data_i = nwd;
    wrd_en_i = wre; wwr_en_i = wwe; wwr_data_i = wwd;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) mdl[k] = 0;
    @(negedge clk_i);
    drive(8'hFF, 8'h00, 32'h0, 1'b1, 1'b0, 32'h0);
    cycle("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    cycle("R1");
    // R9: all narrow ports write distinct values at once
    drive(8'h00, 8'hFF, 32'h8765_4321, 1'b1, 1'b0, 32'h0);
    cycle("R9");
    drive(8'hFF, 8'h00, 32'h0, 1'b1, 1'b0, 32'h0);
    cycle("R2");
    // R4: partial write with bypass on selected reads
    drive(8'h5A, 8'h3C, 32'hABCD_EF01, 1'b1, 1'b0, 32'h0);
    cycle("R2");
    drive(8'hFF, 8'h00, 32'h0, 1'b0, 1'b0, 32'h0);
    cycle("R2");
    // R5: wide write, then narrow reads
    drive(8'h00, 8'h00, 32'h0, 1'b0, 1'b1, 32'h1357_9BDF);
    cycle("R5");
    drive(8'hFF, 8'h00, 32'h0, 1'b1, 1'b0, 32'h0);
    cycle("R5");
    // R7: wide/narrow conflict on alternating nibbles, both views read
    drive(8'hFF, 8'hAA, 32'hEEEE_EEEE, 1'b1, 1'b1, 32'h2222_2222);
    cycle("R7");
    drive(8'hFF, 8'h00, 32'h0, 1'b1, 1'b0, 32'h0);
    cycle("R7");
    // narrow writes then wide read
    drive(8'h00, 8'h81, 32'hC000_000D, 1'b0, 1'b0, 32'h0);
    cycle("R2");
    drive(8'h00, 8'h00, 32'h0, 1'b1, 1'b0, 32'h0);
    cycle("R6");
    // random mix
    for (int i = 0; i < 400; i++) begin
      drive(8'($urandom), 8'($urandom), $urandom, 1'($urandom),
            ($urandom % 3) == 0, $urandom);
      cycle("R9");
    end
    // R1: asynchronous reset mid-run
    drive(8'h00, 8'h00, 32'h0, 1'b0, 1'b0, 32'h0);
    rst_ni = 1'b0;
    for (int k = 0; k < N; k++) mdl[k] = 0;
    #1;
    drive(8'hFF, 8'h00, 32'h0, 1'b1, 1'b0, 32'h0);
    cycle("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    cycle("R1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule